// File: doc/BRIEF.md
# SPI Event-Buffer Responder

This block is an SPI slave that lets an external host drain a queue of event bytes produced on chip. Local logic loads bytes through a push port. While any byte is waiting, the block holds its interrupt output high. The host answers the interrupt by lowering chip select and clocking a frame in SPI mode 0. Data is captured on the rising SCLK edge and changed on the falling edge, most significant bit first.

Every frame opens with a five-byte header. The host's first header byte is a command: 0x0B asks to read and 0x0A asks to write. The host sends zeros in the other four header bytes. While the header is clocked, the slave returns five bytes:
- a ready marker,
- a constant free-space figure for the write side,
- the number of bytes queued at the moment chip select fell.

After the header, a read frame streams queued bytes in order. Any other frame returns 0xFF, and the queue is left as it was. After reset, a built-in generator loads a fixed six-byte reset event before the push port opens, so the host always finds that event first.

The SPI pins are sampled in the system clock domain. SCLK must therefore be slow enough that each half period spans at least five system clocks.

Top module: `evt_spi_slave`

## Requirements
- R1: While chip select is high, MISO is driven to 1.
- R2: The MISO header starts with 0x02 (byte 0). Header bytes 1 and 2 carry the parameter WR_SPACE little-endian, which is 0x7F then 0x00 by default.
- R3: Header bytes 3 and 4 carry, little-endian, the number of bytes queued when chip select fell.
- R4: After reset is released, the queue holds 04 FF 03 01 00 01 and IRQ goes high. Until that load completes, the push port is not ready.
- R5: When the first MOSI header byte is 0x0B, each following 8-clock byte returns the next queued byte, in push order, MSB first.
- R6: When the first MOSI header byte is not 0x0B (for example 0x0A or 0x00), every byte after the header reads 0xFF and no queued byte is removed.
- R7: Clocking more payload bytes than are queued returns 0xFF for the extra bytes, and the queue count stays at zero.
- R8: IRQ is high exactly while the queue is non-empty after the reset load. It falls once the last queued byte has been fully clocked out.
- R9: If chip select rises in the middle of a payload byte, that byte stays queued, and the next frame restarts at header byte 0.
- R10: push_ready_o is low when the queue holds DEPTH bytes (default 8). A push offered while it is low is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | SPI clock from host, idle low |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Host-to-slave data |
| miso_o | output | 1 | Slave-to-host data, high when deselected |
| irq_o | output | 1 | High while event bytes are pending |
| push_valid_i | input | 1 | Local byte offered to the queue |
| push_data_i | input | 8 | Byte to queue |
| push_ready_o | output | 1 | Queue can accept a byte this cycle |

## Verification
The hardest situation to reach from the ports is a frame cut off in the middle of a payload byte. At that point the next byte has already been loaded into the shifter, but it must not be consumed. The bench pushes three bytes, sends a read header, and clocks only four bits of the first payload byte before raising chip select. The next frame's header count and payload must then show all three bytes intact. The bench also sweeps queue fills from one to DEPTH bytes, reading two bytes past the end of each, so that the empty boundary and the IRQ fall are hit at every fill level.

// File: rtl/evt_spi_pkg.sv
package evt_spi_pkg;
  localparam logic [7:0] CMD_WRITE = 8'h0A;
  localparam logic [7:0] CMD_READ  = 8'h0B;
  localparam logic [7:0] HDR_READY = 8'h02;
  localparam int unsigned EVT_LEN  = 6;

  function automatic logic [7:0] boot_evt_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'h04;
      3'd1:    return 8'hFF;
      3'd2:    return 8'h03;
      3'd3:    return 8'h01;
      3'd4:    return 8'h00;
      default: return 8'h01;
    endcase
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
      s3_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign q_o    = s2_q;
  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;
endmodule

// File: rtl/evt_fifo.sv
module evt_fifo #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          rd_i,
  output logic [7:0]    head_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          wr_en, rd_en;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign wr_en   = wr_i & ~full_o;
  assign rd_en   = rd_i & ~empty_o;
  assign head_o  = mem_q[rptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[wptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_en) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (rd_en) rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_comb a_r10_count_bound: assert (!rst_ni || cnt_q <= CW'(DEPTH));

  a_r7_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !wr_i) |=> cnt_q == '0);
endmodule

// File: rtl/boot_evt_gen.sv
module boot_evt_gen
  import evt_spi_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       full_i,
  output logic       push_o,
  output logic [7:0] data_o,
  output logic       done_o
);
  logic [2:0] idx_q;

  assign done_o = (idx_q == 3'(EVT_LEN));
  assign push_o = ~done_o & ~full_i;
  assign data_o = boot_evt_byte(idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (push_o) idx_q <= idx_q + 1'b1;
  end
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import evt_spi_pkg::*;
#(
  parameter int unsigned CW = 4,
  parameter logic [15:0] WR_SPACE = 16'h007F
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          sclk_rise_i,
  input  logic          sclk_fall_i,
  input  logic          mosi_i,
  input  logic          q_valid_i,
  input  logic          q_empty_i,
  input  logic [7:0]    q_head_i,
  input  logic [CW-1:0] q_count_i,
  output logic          pop_o,
  output logic          miso_o
);
  localparam logic [2:0] PAYLOAD = 3'd5;

  logic [2:0]  bit_cnt_q, byte_cnt_q;
  logic [6:0]  rx_sr_q;
  logic [7:0]  tx_sr_q, cmd_q, nxt_byte;
  logic [15:0] cnt_snap_q;
  logic        from_q_q, nxt_from_q;

  always_comb begin
    nxt_from_q = 1'b0;
    case (byte_cnt_q)
      3'd0: nxt_byte = HDR_READY;
      3'd1: nxt_byte = WR_SPACE[7:0];
      3'd2: nxt_byte = WR_SPACE[15:8];
      3'd3: nxt_byte = cnt_snap_q[7:0];
      3'd4: nxt_byte = cnt_snap_q[15:8];
      default: begin
        if (cmd_q == CMD_READ && q_valid_i && !q_empty_i) begin
          nxt_byte   = q_head_i;
          nxt_from_q = 1'b1;
        end else begin
          nxt_byte = 8'hFF;
        end
      end
    endcase
  end

  // a byte leaves the queue only once its last bit has been clocked
  assign pop_o  = ~cs_i & sclk_rise_i & (bit_cnt_q == 3'd7) & from_q_q;
  assign miso_o = cs_i | tx_sr_q[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q  <= '0;
      byte_cnt_q <= '0;
      rx_sr_q    <= '0;
      tx_sr_q    <= HDR_READY;
      cmd_q      <= '0;
      cnt_snap_q <= '0;
      from_q_q   <= 1'b0;
    end else if (cs_i) begin
      bit_cnt_q  <= '0;
      byte_cnt_q <= '0;
      tx_sr_q    <= HDR_READY;
      cmd_q      <= '0;
      from_q_q   <= 1'b0;
      cnt_snap_q <= q_valid_i ? 16'(q_count_i) : 16'h0;
    end else begin
      if (sclk_rise_i) begin
        rx_sr_q   <= {rx_sr_q[5:0], mosi_i};
        bit_cnt_q <= bit_cnt_q + 1'b1;
        if (bit_cnt_q == 3'd7) begin
          if (byte_cnt_q == 3'd0) cmd_q <= {rx_sr_q, mosi_i};
          if (byte_cnt_q != PAYLOAD) byte_cnt_q <= byte_cnt_q + 1'b1;
        end
      end
      if (sclk_fall_i) begin
        if (bit_cnt_q == 3'd0) begin
          tx_sr_q  <= nxt_byte;
          from_q_q <= nxt_from_q;
        end else begin
          tx_sr_q <= {tx_sr_q[6:0], 1'b1};
        end
      end
    end
  end

  a_r9_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_i) |=> (bit_cnt_q == '0 && byte_cnt_q == '0 && !from_q_q));

  a_r6_no_pop_without_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |-> cmd_q == CMD_READ);
endmodule

// File: rtl/evt_spi_slave.sv
module evt_spi_slave
  import evt_spi_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter logic [15:0] WR_SPACE = 16'h007F,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       cs_ni,
  input  logic       mosi_i,
  output logic       miso_o,
  output logic       irq_o,
  input  logic       push_valid_i,
  input  logic [7:0] push_data_i,
  output logic       push_ready_o
);
  logic [2:0]    pin_q, pin_rise, pin_fall;
  logic          gen_push, gen_done, q_full, q_empty, q_wr, q_pop;
  logic [7:0]    gen_data, q_wdata, q_head;
  logic [CW-1:0] q_count;

  // pin order: {cs_n, sclk, mosi}
  spi_in_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni,
    .d_i({cs_ni, sclk_i, mosi_i}),
    .q_o(pin_q), .rise_o(pin_rise), .fall_o(pin_fall)
  );

  boot_evt_gen u_gen (
    .clk_i, .rst_ni, .full_i(q_full),
    .push_o(gen_push), .data_o(gen_data), .done_o(gen_done)
  );

  assign push_ready_o = gen_done & ~q_full;
  assign q_wr         = gen_push | (push_valid_i & push_ready_o);
  assign q_wdata      = gen_done ? push_data_i : gen_data;
  assign irq_o        = gen_done & ~q_empty;

  evt_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .wr_i(q_wr), .wr_data_i(q_wdata), .rd_i(q_pop),
    .head_o(q_head), .full_o(q_full), .empty_o(q_empty), .count_o(q_count)
  );

  spi_frame #(.CW(CW), .WR_SPACE(WR_SPACE)) u_frame (
    .clk_i, .rst_ni,
    .cs_i(pin_q[2]), .sclk_rise_i(pin_rise[1]), .sclk_fall_i(pin_fall[1]),
    .mosi_i(pin_q[0]),
    .q_valid_i(gen_done), .q_empty_i(q_empty), .q_head_i(q_head),
    .q_count_i(q_count), .pop_o(q_pop), .miso_o(miso_o)
  );

  initial a_r4_depth_fits: assert (DEPTH >= EVT_LEN);

  a_r8_irq_fall_on_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(q_pop));

  a_r4_boot_loaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gen_done) |-> q_count == CW'(EVT_LEN));

  a_r1_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_q[2] |-> miso_o);
endmodule

// File: tb/evt_spi_slave_test.sv
module evt_spi_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int DEPTH = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic push_valid = 1'b0;
  logic [7:0] push_data = 8'h00;
  logic miso, irq, push_ready;
  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_spi_slave #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .irq_o(irq), .push_valid_i(push_valid), .push_data_i(push_data),
    .push_ready_o(push_ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input int nbits = 8);
    rx = 8'hFF;
    for (int b = 7; b > 7 - nbits; b--) begin
      mosi = tx[b];
      repeat (HALF) @(negedge clk);
      rx[b] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic frame_begin();
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frame_end();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic header(input logic [7:0] cmd, input int exp_cnt);
    logic [7:0] rx;
    xfer(cmd, rx);       chk("R2 ready", rx, 8'h02);
    xfer(8'h00, rx);     chk("R2 space lo", rx, 8'h7F);
    xfer(8'h00, rx);     chk("R2 space hi", rx, 8'h00);
    xfer(8'h00, rx);     chk("R3 count lo", rx, exp_cnt & 8'hFF);
    xfer(8'h00, rx);     chk("R3 count hi", rx, exp_cnt >> 8);
  endtask

  task automatic push(input logic [7:0] d, output bit acc);
    @(negedge clk);
    push_valid = 1'b1;
    push_data  = d;
    acc = push_ready;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int n, input int k);
    return 8'((n * 37 + k * 11 + 5) & 8'hFF);
  endfunction

  initial begin
    logic [7:0] rx;
    logic [7:0] boot [6] = '{8'h04, 8'hFF, 8'h03, 8'h01, 8'h00, 8'h01};
    bit acc;
    repeat (3) @(negedge clk);
    chk("R1 miso idle in reset", miso, 1);
    chk("R8 irq low in reset", irq, 0);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    chk("R4 irq after boot", irq, 1);
    chk("R1 miso idle", miso, 1);

    // write command: payload reads FF, queue kept
    frame_begin(); header(8'h0A, 6);
    for (int i = 0; i < 6; i++) begin xfer(8'h55, rx); chk("R6 write frame payload", rx, 8'hFF); end
    frame_end();
    chk("R6 irq kept", irq, 1);
    frame_begin(); header(8'h00, 6);
    xfer(8'h00, rx); chk("R6 other cmd payload", rx, 8'hFF);
    frame_end();

    // read the boot event
    frame_begin(); header(8'h0B, 6);
    for (int i = 0; i < 6; i++) begin xfer(8'h00, rx); chk("R4 R5 boot byte", rx, boot[i]); end
    frame_end();
    chk("R8 irq cleared", irq, 0);
    frame_begin(); header(8'h0B, 0);
    xfer(8'h00, rx); chk("R7 empty read", rx, 8'hFF);
    frame_end();

    // sweep fill levels
    for (int n = 1; n <= DEPTH; n++) begin
      for (int k = 0; k < n; k++) begin push(pat(n, k), acc); chk("R10 accepted", acc, 1); end
      repeat (2) @(negedge clk);
      chk("R8 irq pending", irq, 1);
      frame_begin(); header(8'h0B, n);
      for (int k = 0; k < n + 2; k++) begin
        xfer(8'h00, rx);
        if (k < n) chk("R5 payload", rx, pat(n, k));
        else       chk("R7 overrun", rx, 8'hFF);
      end
      frame_end();
      chk("R8 irq after drain", irq, 0);
    end
    frame_begin(); header(8'h0B, 0); frame_end();

    // abort mid payload byte
    for (int k = 0; k < 3; k++) push(pat(20, k), acc);
    frame_begin(); header(8'h0B, 3);
    xfer(8'h00, rx, 4); chk("R9 partial bits", rx[7:4], pat(20, 0) >> 4);
    frame_end();
    chk("R9 irq kept", irq, 1);
    frame_begin(); header(8'h0B, 3);
    for (int k = 0; k < 3; k++) begin xfer(8'h00, rx); chk("R9 byte kept", rx, pat(20, k)); end
    frame_end();

    // overfill
    for (int k = 0; k < DEPTH + 2; k++) begin
      push(pat(30, k), acc);
      chk("R10 ready vs fill", acc, (k < DEPTH) ? 1 : 0);
    end
    chk("R10 ready low when full", push_ready, 0);
    frame_begin(); header(8'h0B, DEPTH);
    for (int k = 0; k < DEPTH + 1; k++) begin
      xfer(8'h00, rx);
      chk("R10 kept bytes", rx, (k < DEPTH) ? pat(30, k) : 8'hFF);
    end
    frame_end();
    chk("R8 irq final", irq, 0);
    chk("R1 miso idle end", miso, 1);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule